// File: doc/BRIEF.md
# Scan Counter Rate Monitor

This block sits on the host side of a link to a remote sensing device. The device has a free-running 8-bit scan counter that is supposed to advance at a steady rate. At a fixed interval the monitor asks for the current counter value through a simple request/response handshake. It then works out how far the counter moved since the last reading, taking the wrap from 255 to 0 into account, and compares that step against an expected increment with a symmetric tolerance.

For example, with one reading every 100 ms and an expected step of 10, a healthy counter goes all the way round its 256 values in 25 or 26 readings. A step that is too small (a slow or stuck counter) or too large (a fast counter) is reported as a rate fault. A request that gets no reply in time is reported as a separate timeout fault. The block only reports these faults. Whatever reacts to them lives outside it.

Top module: `scan_rate_monitor`

## Requirements
- R1: After reset, `req_o`, `fault_evt_o`, `rate_fault_o` and `timeout_fault_o` are 0, and `fault_count_o` and `delta_o` are 0.
- R2: `req_o` pulses high for exactly one cycle once every `INTERVAL_CYCLES` cycles. No new request is issued while one is outstanding.
- R3: A response (`rsp_valid_i` high) is accepted only while a request is outstanding. The window starts in the cycle `req_o` is high and lasts `RSP_TIMEOUT` cycles in total. A response arriving at any other time is ignored and does not change the stored value.
- R4: The first accepted sample after reset, and the first after a timeout, only stores the value. It is never flagged and leaves `delta_o` unchanged.
- R5: For every later accepted sample, `delta_o` shows (new − previous) mod 256 from the cycle after the response. This holds across the 255→0 wrap.
- R6: A delta in the range [`EXP_DELTA`−`TOL`, `EXP_DELTA`+`TOL`] (default 9..11) raises no fault. Any other delta pulses `fault_evt_o` for one cycle, in the cycle after the response.
- R7: `rate_fault_o` is set by every fault event and stays set until `clear_i`.
- R8: `fault_count_o` counts fault events and saturates at 255.
- R9: `clear_i` resets `rate_fault_o` and `fault_count_o`. If a fault event lands in the same cycle as the clear, the result is `rate_fault_o`=1 and `fault_count_o`=1.
- R10: If no response arrives within the window, `timeout_fault_o` sets and stays set until `clear_i`. A timeout in the same cycle as a clear wins. After a timeout, the next sample re-initialises the stored value as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Clears the sticky faults and the fault count |
| req_o | output | 1 | One-cycle read request for the remote counter |
| rsp_valid_i | input | 1 | Response strobe carrying the counter value |
| rsp_data_i | input | 8 | Counter value returned with the response |
| delta_o | output | 8 | Last computed modulo-256 step |
| fault_evt_o | output | 1 | One-cycle pulse for each out-of-window step |
| rate_fault_o | output | 1 | Sticky rate fault |
| fault_count_o | output | 8 | Saturating count of rate faults |
| timeout_fault_o | output | 1 | Sticky response-timeout fault |

## Verification
Two things can land on the same clock edge: the software clear, and the arrival of a new fault. This happens both for the rate-fault sticky bit and counter, and for the timeout sticky bit. The bench drives `clear_i` in the very cycle the bad response is presented. It also drives `clear_i` in the last cycle of the response window, so the timeout fires on the same edge. In both cases the new fault must survive: rate fault 1 and count 1 in the first case, timeout set in the second. A separate clear on its own must then return both to zero.

// File: rtl/smr_pkg.sv
package smr_pkg;
    typedef enum logic {
        FETCH_IDLE = 1'b0,
        FETCH_WAIT = 1'b1
    } fetch_state_e;
endpackage

// File: rtl/smr_tick_gen.sv
module smr_tick_gen #(
    parameter int INTERVAL_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int TW = (INTERVAL_CYCLES > 1) ? $clog2(INTERVAL_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYCLES - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          tick;
    } tick_s;

    tick_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (s_q.cnt == LAST) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.tick;
endmodule

// File: rtl/smr_fetch.sv
module smr_fetch
    import smr_pkg::*;
#(
    parameter int RSP_TIMEOUT = 64,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              clear_i,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              req_o,
    output logic              sample_vld_o,
    output logic [DATA_W-1:0] sample_data_o,
    output logic              timeout_evt_o,
    output logic              timeout_fault_o
);
    localparam int WW = $clog2(RSP_TIMEOUT + 1);
    localparam logic [WW-1:0] WAIT_LAST = WW'(RSP_TIMEOUT - 1);

    typedef struct packed {
        fetch_state_e  st;
        logic [WW-1:0] wcnt;
        logic          req;
        logic          to_sticky;
    } fetch_s;

    fetch_s s_d, s_q;
    logic   accept;
    logic   to_evt;

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        accept  = 1'b0;
        to_evt  = 1'b0;
        case (s_q.st)
            FETCH_IDLE: begin
                if (tick_i) begin
                    s_d.st   = FETCH_WAIT;
                    s_d.wcnt = '0;
                    s_d.req  = 1'b1;
                end
            end
            FETCH_WAIT: begin
                if (rsp_valid_i) begin
                    accept = 1'b1;
                    s_d.st = FETCH_IDLE;
                end else if (s_q.wcnt == WAIT_LAST) begin
                    to_evt = 1'b1;
                    s_d.st = FETCH_IDLE;
                end else begin
                    s_d.wcnt = s_q.wcnt + 1'b1;
                end
            end
            default: s_d.st = FETCH_IDLE;
        endcase
        if (clear_i) s_d.to_sticky = 1'b0;
        if (to_evt)  s_d.to_sticky = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: FETCH_IDLE, wcnt: '0, req: 1'b0, to_sticky: 1'b0};
        else        s_q <= s_d;
    end

    assign req_o           = s_q.req;
    assign sample_vld_o    = accept;
    assign sample_data_o   = rsp_data_i;
    assign timeout_evt_o   = to_evt;
    assign timeout_fault_o = s_q.to_sticky;
endmodule

// File: rtl/smr_delta_check.sv
module smr_delta_check #(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 8,
    parameter int EXP_DELTA = 10,
    parameter int TOL       = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              sample_vld_i,
    input  logic [DATA_W-1:0] sample_data_i,
    input  logic              resync_i,
    output logic [DATA_W-1:0] delta_o,
    output logic              fault_evt_o,
    output logic              rate_fault_o,
    output logic [CNT_W-1:0]  fault_count_o
);
    localparam logic [DATA_W-1:0] LO_LIM  = DATA_W'(EXP_DELTA - TOL);
    localparam logic [DATA_W-1:0] HI_LIM  = DATA_W'(EXP_DELTA + TOL);
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;

    typedef struct packed {
        logic [DATA_W-1:0] prev;
        logic              have_prev;
        logic [DATA_W-1:0] delta;
        logic              evt;
        logic              sticky;
        logic [CNT_W-1:0]  cnt;
    } chk_s;

    chk_s              s_d, s_q;
    logic [DATA_W-1:0] step;
    logic              out_of_window;

    always_comb begin
        s_d           = s_q;
        s_d.evt       = 1'b0;
        step          = sample_data_i - s_q.prev;
        out_of_window = (step < LO_LIM) || (step > HI_LIM);
        if (sample_vld_i) begin
            if (s_q.have_prev) begin
                s_d.delta = step;
                s_d.evt   = out_of_window;
            end
            s_d.prev      = sample_data_i;
            s_d.have_prev = 1'b1;
        end
        if (resync_i) s_d.have_prev = 1'b0;
        if (clear_i) begin
            s_d.sticky = 1'b0;
            s_d.cnt    = '0;
        end
        if (s_d.evt) begin
            s_d.sticky = 1'b1;
            if (clear_i)               s_d.cnt = CNT_W'(1);
            else if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign delta_o       = s_q.delta;
    assign fault_evt_o   = s_q.evt;
    assign rate_fault_o  = s_q.sticky;
    assign fault_count_o = s_q.cnt;
endmodule

// File: rtl/scan_rate_monitor.sv
module scan_rate_monitor #(
    parameter int INTERVAL_CYCLES = 1000,
    parameter int RSP_TIMEOUT     = 64,
    parameter int EXP_DELTA       = 10,
    parameter int TOL             = 1,
    parameter int DATA_W          = 8,
    parameter int CNT_W           = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    output logic              req_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic [DATA_W-1:0] delta_o,
    output logic              fault_evt_o,
    output logic              rate_fault_o,
    output logic [CNT_W-1:0]  fault_count_o,
    output logic              timeout_fault_o
);
    logic              tick;
    logic              sample_vld;
    logic [DATA_W-1:0] sample_data;
    logic              timeout_evt;

    smr_tick_gen #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    smr_fetch #(.RSP_TIMEOUT(RSP_TIMEOUT), .DATA_W(DATA_W)) u_fetch (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_i          (tick),
        .clear_i         (clear_i),
        .rsp_valid_i     (rsp_valid_i),
        .rsp_data_i      (rsp_data_i),
        .req_o           (req_o),
        .sample_vld_o    (sample_vld),
        .sample_data_o   (sample_data),
        .timeout_evt_o   (timeout_evt),
        .timeout_fault_o (timeout_fault_o)
    );

    smr_delta_check #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .EXP_DELTA(EXP_DELTA), .TOL(TOL)
    ) u_check (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (clear_i),
        .sample_vld_i  (sample_vld),
        .sample_data_i (sample_data),
        .resync_i      (timeout_evt),
        .delta_o       (delta_o),
        .fault_evt_o   (fault_evt_o),
        .rate_fault_o  (rate_fault_o),
        .fault_count_o (fault_count_o)
    );
endmodule

// File: rtl/scan_rate_monitor_sva.sv
module scan_rate_monitor_sva #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_i,
    input logic              req_o,
    input logic              rsp_valid_i,
    input logic [DATA_W-1:0] rsp_data_i,
    input logic [DATA_W-1:0] delta_o,
    input logic              fault_evt_o,
    input logic              rate_fault_o,
    input logic [CNT_W-1:0]  fault_count_o,
    input logic              timeout_fault_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    p_req_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    p_evt_after_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt_o |-> $past(rsp_valid_i));

    p_evt_sets_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt_o |-> rate_fault_o);

    p_rate_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_fault_o && !clear_i) |=> rate_fault_o);

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_count_o == CMAX && !clear_i) |=> fault_count_o == CMAX);

    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (fault_count_o == (fault_evt_o ? 1 : 0)));

    p_timeout_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_fault_o && !clear_i) |=> timeout_fault_o);

    p_timeout_not_during_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_fault_o) |-> !req_o);
endmodule

bind scan_rate_monitor scan_rate_monitor_sva #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sva (.*);

// File: tb/scan_rate_monitor_tb.sv
module scan_rate_monitor_tb_top;
    localparam int IVL = 32;
    localparam int TO  = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic       req_o;
    logic       rsp_valid_i = 1'b0;
    logic [7:0] rsp_data_i = 8'h00;
    logic [7:0] delta_o;
    logic       fault_evt_o;
    logic       rate_fault_o;
    logic [7:0] fault_count_o;
    logic       timeout_fault_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_req = 0;
    int prev_req = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scan_rate_monitor #(.INTERVAL_CYCLES(IVL), .RSP_TIMEOUT(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .req_o(req_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .delta_o(delta_o),
        .fault_evt_o(fault_evt_o), .rate_fault_o(rate_fault_o),
        .fault_count_o(fault_count_o), .timeout_fault_o(timeout_fault_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_req();
        forever begin
            @(negedge clk);
            if (req_o) break;
        end
        prev_req = last_req;
        last_req = cyc;
    endtask

    // waits for a request, replies after lat negedges; outputs valid on return
    task automatic sample(input logic [7:0] val, input int lat, input logic clr);
        wait_req();
        repeat (lat) @(negedge clk);
        rsp_valid_i = 1'b1;
        rsp_data_i  = val;
        clear_i     = clr;
        @(negedge clk);
        rsp_valid_i = 1'b0;
        clear_i     = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 req", req_o, 0);
        chk("R1 evt", fault_evt_o, 0);
        chk("R1 rate", rate_fault_o, 0);
        chk("R1 timeout", timeout_fault_o, 0);
        chk("R1 count", fault_count_o, 0);
        chk("R1 delta", delta_o, 0);
    endtask

    task automatic t_first_and_nominal();
        sample(8'd200, 2, 1'b0);
        chk("R4 first evt", fault_evt_o, 0);
        chk("R4 first delta", delta_o, 0);
        sample(8'd210, 3, 1'b0);
        chk("R2 period", last_req - prev_req, IVL);
        chk("R5 delta", delta_o, 10);
        chk("R6 nominal evt", fault_evt_o, 0);
    endtask

    task automatic t_edges_and_wrap();
        sample(8'd219, 1, 1'b0);
        chk("R6 low edge evt", fault_evt_o, 0);
        sample(8'd230, 1, 1'b0);
        chk("R6 high edge evt", fault_evt_o, 0);
        chk("R6 high edge delta", delta_o, 11);
        sample(8'd240, 1, 1'b0);
        sample(8'd250, 1, 1'b0);
        sample(8'd4, 1, 1'b0);
        chk("R5 wrap delta", delta_o, 10);
        chk("R5 wrap evt", fault_evt_o, 0);
        for (int i = 1; i <= 26; i++) sample(8'(4 + 10 * i), 2, 1'b0);
        chk("R5 full lap count", fault_count_o, 0);
        chk("R5 full lap rate", rate_fault_o, 0);
    endtask

    task automatic t_bad_steps();
        // previous value is 8
        sample(8'd16, 1, 1'b0);
        chk("R6 slow evt", fault_evt_o, 1);
        chk("R7 slow rate", rate_fault_o, 1);
        chk("R8 slow count", fault_count_o, 1);
        @(negedge clk);
        chk("R6 evt one cycle", fault_evt_o, 0);
        sample(8'd28, 1, 1'b0);
        chk("R6 fast delta", delta_o, 12);
        chk("R8 fast count", fault_count_o, 2);
        sample(8'd28, 1, 1'b0);
        chk("R6 stuck delta", delta_o, 0);
        chk("R8 stuck count", fault_count_o, 3);
        chk("R7 still set", rate_fault_o, 1);
    endtask

    task automatic t_window_and_clear();
        sample(8'd38, TO - 1, 1'b0);
        chk("R3 last window cycle delta", delta_o, 10);
        chk("R3 last window cycle evt", fault_evt_o, 0);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk("R9 clear rate", rate_fault_o, 0);
        chk("R9 clear count", fault_count_o, 0);
        sample(8'd43, 1, 1'b1);
        chk("R9 collide rate", rate_fault_o, 1);
        chk("R9 collide count", fault_count_o, 1);
        // stray response while idle
        @(negedge clk);
        rsp_valid_i = 1'b1;
        rsp_data_i  = 8'd99;
        @(negedge clk);
        rsp_valid_i = 1'b0;
        chk("R3 stray delta", delta_o, 5);
        sample(8'd53, 1, 1'b0);
        chk("R3 stray ignored delta", delta_o, 10);
        chk("R3 stray ignored evt", fault_evt_o, 0);
    endtask

    task automatic t_timeout();
        wait_req();
        repeat (TO - 1) @(negedge clk);
        chk("R10 not yet", timeout_fault_o, 0);
        @(negedge clk);
        chk("R10 timeout", timeout_fault_o, 1);
        chk("R10 count kept", fault_count_o, 1);
        sample(8'd170, 1, 1'b0);
        chk("R4 resync evt", fault_evt_o, 0);
        chk("R4 resync delta", delta_o, 10);
        sample(8'd180, 1, 1'b0);
        chk("R10 after resync evt", fault_evt_o, 0);
        // timeout coinciding with clear
        wait_req();
        repeat (TO - 1) @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk("R10 timeout beats clear", timeout_fault_o, 1);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk("R10 clear alone", timeout_fault_o, 0);
    endtask

    task automatic t_saturate();
        sample(8'd50, 1, 1'b0);
        chk("R4 init after timeout", fault_evt_o, 0);
        for (int i = 0; i < 255; i++) sample(8'd50, 1, 1'b0);
        chk("R8 reaches max", fault_count_o, 255);
        sample(8'd50, 1, 1'b0);
        chk("R8 saturated", fault_count_o, 255);
        chk("R8 evt at max", fault_evt_o, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_and_nominal();
        t_edges_and_wrap();
        t_bad_steps();
        t_window_and_clear();
        t_timeout();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule